// File: doc/BRIEF.md
# ECC Syndrome Checker and Error Locator

This block takes the 24-bit ECC computed over a 512-byte data sector while it is read back and compares it with the 24-bit ECC held in the page's spare area. It sorts the outcome into one of four classes: clean data, a single data bit that can be corrected, damage inside the stored ECC field only, or an uncorrectable multi-bit error. For the correctable class it also gives the byte offset inside the sector and the bit position inside that byte, so that a later stage can flip that bit.

The ECC word is made of twelve parity pairs. Pair `i` sits in bits `2i+1` (the odd parity, over data bits whose address bit `i` is 1) and `2i` (the even parity, over data bits whose address bit `i` is 0). Address bits 0..2 select the bit within a byte, and address bits 3..11 select the byte. The caller pulses `chk_stb` with both ECC words present. The result is registered on the next clock edge and holds until the next pulse.

Top module: `ecc_syndrome_checker`

## Requirements
- R1: The syndrome is `ecc_calc ^ ecc_stored`. On a clock edge where `chk_stb` is 1, the outputs take the result for that syndrome, and it is visible after that edge.
- R2: An all-zero syndrome gives `status` = 0 (clean).
- R3: A syndrome whose twelve pairs (bits `2i+1`,`2i`) each hold exactly one 1 gives `status` = 1 (correctable).
- R4: For `status` = 1, form a 12-bit address where address bit `i` = syndrome bit `2i+1`. `err_byte` is address bits 11..3 and `err_bit` is address bits 2..0.
- R5: A syndrome with exactly one bit set gives `status` = 2 (error in the stored ECC field; the data is good).
- R6: Any other nonzero syndrome gives `status` = 3 (uncorrectable).
- R7: While `chk_stb` is 0, `status`, `err_byte` and `err_bit` keep their values, whatever the ECC inputs do.
- R8: `err_byte` and `err_bit` are zero whenever `status` is not 1.
- R9: After reset, `status`, `err_byte` and `err_bit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously inside |
| chk_stb | input | 1 | Check request; samples both ECC words |
| ecc_calc | input | 24 | ECC computed from the data just read |
| ecc_stored | input | 24 | ECC read from the spare area |
| status | output | 2 | 0 clean, 1 correctable, 2 ECC field error, 3 uncorrectable |
| err_byte | output | 9 | Byte offset of the bad bit (correctable case only) |
| err_bit | output | 3 | Bit position within the byte (correctable case only) |

## Verification
The hardest class to reach is the correctable one. Only 4096 of the 2^24 syndromes fall into it, so random ECC pairs almost never produce it. The bench builds each of these syndromes directly from a sweep over every byte and bit address. It XORs the syndrome onto a changing base word, so the stored and computed words are not trivial. It then sweeps every one-bit and two-bit syndrome, and takes correctable patterns with one pair forced to 11 or 00. These cover the boundaries between the ECC field error, correctable and uncorrectable classes.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  typedef enum logic [1:0] {
    ECC_ST_CLEAN    = 2'd0,
    ECC_ST_FIXABLE  = 2'd1,
    ECC_ST_CODE_ERR = 2'd2,
    ECC_ST_MULTI    = 2'd3
  } ecc_status_e;

endpackage

// File: rtl/ecc_syndrome_form.sv
module ecc_syndrome_form #(
  parameter int ECC_W = 24
) (
  input  logic [ECC_W-1:0] calc_i,
  input  logic [ECC_W-1:0] stored_i,
  output logic [ECC_W-1:0] syn_o
);

  always_comb begin
    syn_o = calc_i ^ stored_i;
  end

endmodule

// File: rtl/ecc_pair_classify.sv
module ecc_pair_classify
  import ecc_chk_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int ECC_W = 2 * ADDR_W
) (
  input  logic [ECC_W-1:0] syn_i,
  output ecc_status_e      class_o
);

  logic [ADDR_W-1:0] pair_split;
  logic              all_split;
  logic              any_set;
  logic              lone_bit;

  // one flag per odd/even pair: set when exactly one of the two is 1
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_pair
    assign pair_split[gi] = syn_i[2*gi+1] ^ syn_i[2*gi];
  end

  always_comb begin
    all_split = &pair_split;
    any_set   = |syn_i;
    lone_bit  = any_set && ((syn_i & (syn_i - ECC_W'(1))) == '0);
  end

  always_comb begin
    if (!any_set) begin
      class_o = ECC_ST_CLEAN;
    end else if (all_split) begin
      class_o = ECC_ST_FIXABLE;
    end else if (lone_bit) begin
      class_o = ECC_ST_CODE_ERR;
    end else begin
      class_o = ECC_ST_MULTI;
    end
  end

endmodule

// File: rtl/ecc_bit_locate.sv
module ecc_bit_locate #(
  parameter int ADDR_W = 12,
  localparam int ECC_W = 2 * ADDR_W
) (
  input  logic [ECC_W-1:0]  syn_i,
  output logic [ADDR_W-1:0] addr_o
);

  // the odd member of each pair carries one address bit
  logic [ADDR_W-1:0] even_unused;

  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_addr
    assign addr_o[gi]      = syn_i[2*gi+1];
    assign even_unused[gi] = syn_i[2*gi];
  end

  logic unused_ok;
  assign unused_ok = ^even_unused;

endmodule

// File: rtl/ecc_syndrome_checker.sv
module ecc_syndrome_checker
  import ecc_chk_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BIT_IDX_W = 3,
  localparam int ECC_W    = 2 * ADDR_W,
  localparam int BYTE_W   = ADDR_W - BIT_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_stb,
  input  logic [ECC_W-1:0]  ecc_calc,
  input  logic [ECC_W-1:0]  ecc_stored,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] err_byte,
  output logic [BIT_IDX_W-1:0] err_bit
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [ECC_W-1:0]  syn;
  ecc_status_e       cls;
  logic [ADDR_W-1:0] loc;

  ecc_syndrome_form #(.ECC_W(ECC_W)) u_form (
    .calc_i   (ecc_calc),
    .stored_i (ecc_stored),
    .syn_o    (syn)
  );

  ecc_pair_classify #(.ADDR_W(ADDR_W)) u_class (
    .syn_i   (syn),
    .class_o (cls)
  );

  ecc_bit_locate #(.ADDR_W(ADDR_W)) u_loc (
    .syn_i  (syn),
    .addr_o (loc)
  );

  ecc_status_e       status_q, status_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              res_en;

  always_comb begin
    res_en   = chk_stb;
    status_d = cls;
    addr_d   = (cls == ECC_ST_FIXABLE) ? loc : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= ECC_ST_CLEAN;
      addr_q   <= '0;
    end else if (res_en) begin
      status_q <= status_d;
      addr_q   <= addr_d;
    end
  end

  assign status   = status_q;
  assign err_byte = addr_q[ADDR_W-1:BIT_IDX_W];
  assign err_bit  = addr_q[BIT_IDX_W-1:0];

endmodule

// File: rtl/ecc_syndrome_checker_sva.sv
module ecc_syndrome_checker_sva #(
  parameter int ADDR_W    = 12,
  parameter int BIT_IDX_W = 3,
  localparam int ECC_W    = 2 * ADDR_W,
  localparam int BYTE_W   = ADDR_W - BIT_IDX_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chk_stb,
  input logic [ECC_W-1:0]     ecc_calc,
  input logic [ECC_W-1:0]     ecc_stored,
  input logic [1:0]           status,
  input logic [BYTE_W-1:0]    err_byte,
  input logic [BIT_IDX_W-1:0] err_bit
);

  function automatic logic [ADDR_W-1:0] odd_bits(input logic [ECC_W-1:0] s);
    logic [ADDR_W-1:0] r;
    for (int i = 0; i < ADDR_W; i++) r[i] = s[2*i+1];
    return r;
  endfunction

  function automatic logic pairs_split(input logic [ECC_W-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ADDR_W; i++) ok = ok & (s[2*i+1] != s[2*i]);
    return ok;
  endfunction

  // R2
  p_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb && (ecc_calc == ecc_stored) |=> status == 2'd0);

  // R3
  p_fixable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb && pairs_split(ecc_calc ^ ecc_stored) |=> status == 2'd1);

  // R4
  p_locate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb |=> (status != 2'd1) ||
      ({err_byte, err_bit} == odd_bits($past(ecc_calc ^ ecc_stored))));

  // R5
  p_code_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb && ($countones(ecc_calc ^ ecc_stored) == 1) |=> status == 2'd2);

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_stb |=> $stable(status) && $stable(err_byte) && $stable(err_bit));

  // R8
  p_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd1 |-> (err_byte == '0) && (err_bit == '0));

endmodule

bind ecc_syndrome_checker ecc_syndrome_checker_sva #(
  .ADDR_W    (ADDR_W),
  .BIT_IDX_W (BIT_IDX_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .chk_stb    (chk_stb),
  .ecc_calc   (ecc_calc),
  .ecc_stored (ecc_stored),
  .status     (status),
  .err_byte   (err_byte),
  .err_bit    (err_bit)
);

// File: tb/tb_ecc_syndrome_checker.sv
`timescale 1ns/1ps
module tb_ecc_syndrome_checker;

  logic        clk;
  logic        rst_n;
  logic        chk_stb;
  logic [23:0] ecc_calc;
  logic [23:0] ecc_stored;
  logic [1:0]  status;
  logic [8:0]  err_byte;
  logic [2:0]  err_bit;

  int n_chk;
  int n_fail;
  logic [23:0] base;

  ecc_syndrome_checker dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_stb    (chk_stb),
    .ecc_calc   (ecc_calc),
    .ecc_stored (ecc_stored),
    .status     (status),
    .err_byte   (err_byte),
    .err_bit    (err_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // watchdog
  int cyc;
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  // build the syndrome of a single data bit error at address a
  function automatic logic [23:0] syn_of_addr(input logic [11:0] a);
    logic [23:0] s;
    for (int i = 0; i < 12; i++) begin
      s[2*i+1] = a[i];
      s[2*i]   = ~a[i];
    end
    return s;
  endfunction

  function automatic logic [23:0] next_base(input logic [23:0] b);
    return {b[22:0], b[23] ^ b[22] ^ b[21] ^ b[16]} ^ 24'h5a3c1;
  endfunction

  task automatic expect_out(input string req, input logic [1:0] es,
                            input logic [8:0] eb, input logic [2:0] ei);
    n_chk++;
    if (status !== es || err_byte !== eb || err_bit !== ei) begin
      n_fail++;
      $display("FAIL %s: got st=%0d byte=%0d bit=%0d expected st=%0d byte=%0d bit=%0d",
               req, status, err_byte, err_bit, es, eb, ei);
    end
  endtask

  // apply a syndrome on top of the running base, strobe, then check
  task automatic run(input string req, input logic [23:0] syn,
                     input logic [1:0] es, input logic [8:0] eb, input logic [2:0] ei);
    @(negedge clk);
    base       = next_base(base);
    ecc_calc   = base;
    ecc_stored = base ^ syn;
    chk_stb    = 1'b1;
    @(negedge clk);
    chk_stb    = 1'b0;
    expect_out(req, es, eb, ei);
  endtask

  initial begin
    n_chk      = 0;
    n_fail     = 0;
    base       = 24'h3c96e1;
    rst_n      = 1'b0;
    chk_stb    = 1'b0;
    ecc_calc   = '0;
    ecc_stored = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_out("R9 reset", 2'd0, 9'd0, 3'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out("R9 after release", 2'd0, 9'd0, 3'd0);

    // R1 R2: equal words, several bases
    for (int k = 0; k < 8; k++) run("R1 R2 clean", 24'h0, 2'd0, 9'd0, 3'd0);

    // R3 R4: every byte and bit address
    for (int a = 0; a < 4096; a++) begin
      run("R3 R4 single data bit", syn_of_addr(12'(a)), 2'd1,
          9'(a >> 3), 3'(a & 7));
    end

    // R5 R8: one syndrome bit set, after a correctable result
    for (int b = 0; b < 24; b++) begin
      run("R3 prep", syn_of_addr(12'hfff), 2'd1, 9'h1ff, 3'd7);
      run("R5 R8 ecc field bit", 24'(1) << b, 2'd2, 9'd0, 3'd0);
    end

    // R6: every two-bit syndrome
    for (int b1 = 0; b1 < 24; b1++)
      for (int b2 = b1 + 1; b2 < 24; b2++)
        run("R6 two bits", (24'(1) << b1) | (24'(1) << b2), 2'd3, 9'd0, 3'd0);

    // R6: correctable pattern with one pair broken to 11 or 00
    for (int p = 0; p < 12; p++) begin
      run("R6 pair 11", syn_of_addr(12'h5a5) | (24'd3 << (2*p)), 2'd3, 9'd0, 3'd0);
      run("R6 pair 00", syn_of_addr(12'ha5a) & ~(24'd3 << (2*p)), 2'd3, 9'd0, 3'd0);
    end
    run("R6 all ones", 24'hffffff, 2'd3, 9'd0, 3'd0);

    // R7: change inputs without strobe, result must stay
    run("R4 prep", syn_of_addr(12'h9c3), 2'd1, 9'h138, 3'd3);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ecc_calc   = next_base(ecc_calc);
      ecc_stored = ~ecc_calc;
      @(negedge clk);
      expect_out("R7 hold", 2'd1, 9'h138, 3'd3);
    end

    // R9: reset in mid-run clears the result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R9 async clear", 2'd0, 9'd0, 3'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run("R1 after reset", syn_of_addr(12'h001), 2'd1, 9'd0, 3'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule